// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch Register Bank

This block stores the on/off state of a 12 by 8 analog switch matrix: one enable bit for each pairing of an X line with a Y line, 96 in all. A serial front end delivers 16-bit command words. Each word names one switch, says whether to close or open it, and carries a load flag. Every update lands first in a staging register. A word whose load flag is set copies the whole staging register, including its own update, into the active register. The 96 active enables drive the switch array directly. Because of the staging register, a sequence of switch changes takes effect on one clock edge.

The X code in a command is not contiguous. Codes 6 and 7 are reserved, and the codes above them address X6 to X11. A readback port takes an X code and a Y code and returns the active state of that switch one cycle later. A synchronous active-low reset clears both registers. While reset is held, commands are ignored.

Top module: `xpt_switch_bank`

## Requirements
- R1: While rst_n is low at a clock edge, all active bits, all staged bits and rb_bit are cleared to 0. After reset is released, sw_en and rb_bit read 0.
- R2: An accepted command (cmd_valid=1, rst_n=1) with load flag cmd_word[0]=0 writes only the staged bit. sw_en is unchanged after that edge.
- R3: An accepted command with cmd_word[0]=1 copies the staged register into the active register. The copy includes this command's own update. sw_en shows the result at the edge where the command is taken.
- R4: Every staged update queued since the last load appears in sw_en on the same edge.
- R5: The X code is cmd_word[14:11]. Codes 0..5 select X0..X5, and codes 8..13 select X6..X11.
- R6: The Y code is cmd_word[10:8]. Codes 0..7 select Y0..Y7. Switch (X, Y) is bit sw_en[X*8+Y].
- R7: The data bit is cmd_word[15]. A 1 closes the selected switch (bit 1) and a 0 opens it (bit 0).
- R8: X codes 6, 7, 14 and 15 are reserved. Such a command changes no staged bit, but its load flag still copies the staged register to the active register.
- R9: Commands presented while rst_n is low are ignored. Nothing they carry appears after reset is released, even when a later load occurs.
- R10: rb_bit is registered. One edge after rb_xcode/rb_ycode are applied, it equals the active bit of that switch, decoded as in R5 and R6. A reserved rb_xcode returns 0.
- R11: cmd_word[7:1] has no effect. A word with cmd_valid=0 has no effect.
- R12: Switches are independent. One X line may be closed to several Y lines, and several X lines to one Y line, at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word is present this cycle |
| cmd_word | input | 16 | Command: data, X code, Y code, don't-care bits, load flag |
| rb_xcode | input | 4 | Readback X code |
| rb_ycode | input | 3 | Readback Y code |
| rb_bit | output | 1 | Active state of the addressed switch, one cycle later |
| sw_en | output | 96 | Active switch enables, bit X*8+Y |

## Verification
The switch state is exercised in several ways:
- A single staged word with no load shows that staging is held apart from the active state.
- A run of unloaded words closed by one load shows that all queued changes appear on one edge.
- A sweep of all sixteen X codes with load set separates correct gap mapping from off-by-two or contiguous decoding, and shows that reserved codes write nothing.
- A reserved code carrying a load shows that the copy still happens.
- A reset with commands pending shows that neither register keeps them.
- A row and column fill tells independent bits apart from one-hot behaviour.
- Readback probes cover valid, reserved and cleared addresses.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  parameter int unsigned XN      = 12;
  parameter int unsigned YN      = 8;
  parameter int unsigned XCW     = 4;
  parameter int unsigned YCW     = 3;
  parameter int unsigned CW      = 16;
  parameter int unsigned RSV_LO  = 6;
  parameter int unsigned RSV_N   = 2;
  localparam int unsigned NSW    = XN * YN;
  localparam int unsigned IDXW   = $clog2(NSW);
  localparam int unsigned XIW    = $clog2(XN);
  localparam int unsigned DATA_B = CW - 1;
  localparam int unsigned XC_HI  = CW - 2;
  localparam int unsigned XC_LO  = CW - 1 - XCW;
  localparam int unsigned YC_HI  = XC_LO - 1;
  localparam int unsigned YC_LO  = XC_LO - YCW;
  localparam int unsigned LOAD_B = 0;

  typedef struct packed {
    logic           ok;
    logic [XIW-1:0] xi;
  } xsel_t;

  // Map an X code onto a line index, skipping the reserved gap.
  function automatic xsel_t xcode_map(input logic [XCW-1:0] code);
    xsel_t r;
    int unsigned c;
    c    = int'(code);
    r.ok = 1'b0;
    r.xi = '0;
    if (c < RSV_LO) begin
      r.ok = 1'b1;
      r.xi = XIW'(c);
    end else if (c >= RSV_LO + RSV_N && (c - RSV_N) < XN) begin
      r.ok = 1'b1;
      r.xi = XIW'(c - RSV_N);
    end
    return r;
  endfunction

  function automatic logic [IDXW-1:0] sw_index(input logic [XIW-1:0] xi,
                                               input logic [YCW-1:0] yi);
    return IDXW'(int'(xi) * YN + int'(yi));
  endfunction
endpackage

// File: rtl/xpt_cmd_decode.sv
module xpt_cmd_decode
  import xpt_pkg::*;
(
  input  logic            cmd_valid,
  input  logic [CW-1:0]   cmd_word,
  output logic            wr_en,
  output logic            ld_en,
  output logic            wr_data,
  output logic [IDXW-1:0] wr_idx
);
  xsel_t xs;

  always_comb begin
    xs      = xcode_map(cmd_word[XC_HI:XC_LO]);
    wr_en   = cmd_valid & xs.ok;
    ld_en   = cmd_valid & cmd_word[LOAD_B];
    wr_data = cmd_word[DATA_B];
    wr_idx  = sw_index(xs.xi, cmd_word[YC_HI:YC_LO]);
  end
endmodule

// File: rtl/xpt_stage_bank.sv
module xpt_stage_bank
  import xpt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            ld_en,
  input  logic            wr_data,
  input  logic [IDXW-1:0] wr_idx,
  output logic [NSW-1:0]  staged_q,
  output logic [NSW-1:0]  active_q
);
  logic [NSW-1:0] staged_d;

  for (genvar i = 0; i < NSW; i++) begin : g_cell
    always_comb begin
      staged_d[i] = staged_q[i];
      if (wr_en && wr_idx == IDXW'(i)) staged_d[i] = wr_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        staged_q[i] <= 1'b0;
        active_q[i] <= 1'b0;
      end else begin
        staged_q[i] <= staged_d[i];
        if (ld_en) active_q[i] <= staged_d[i];
      end
    end
  end
endmodule

// File: rtl/xpt_readback.sv
module xpt_readback
  import xpt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [XCW-1:0] rb_xcode,
  input  logic [YCW-1:0] rb_ycode,
  input  logic [NSW-1:0] active_q,
  output logic           rb_q
);
  xsel_t          xs;
  logic [IDXW-1:0] idx;
  logic           sel_bit;

  always_comb begin
    xs      = xcode_map(rb_xcode);
    idx     = sw_index(xs.xi, rb_ycode);
    sel_bit = xs.ok ? active_q[idx] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rb_q <= 1'b0;
    else        rb_q <= sel_bit;
  end
endmodule

// File: rtl/xpt_switch_bank.sv
module xpt_switch_bank
  import xpt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [CW-1:0]       cmd_word,
  input  logic [XCW-1:0]      rb_xcode,
  input  logic [YCW-1:0]      rb_ycode,
  output logic                rb_bit,
  output logic [NSW-1:0]      sw_en
);
  logic            wr_en, ld_en, wr_data;
  logic [IDXW-1:0] wr_idx;
  logic [NSW-1:0]  staged_q, active_q;

  xpt_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .wr_en     (wr_en),
    .ld_en     (ld_en),
    .wr_data   (wr_data),
    .wr_idx    (wr_idx)
  );

  xpt_stage_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .ld_en    (ld_en),
    .wr_data  (wr_data),
    .wr_idx   (wr_idx),
    .staged_q (staged_q),
    .active_q (active_q)
  );

  xpt_readback u_rb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rb_xcode (rb_xcode),
    .rb_ycode (rb_ycode),
    .active_q (active_q),
    .rb_q     (rb_bit)
  );

  assign sw_en = active_q;
endmodule

// File: rtl/xpt_switch_bank_chk.sv
module xpt_switch_bank_chk
  import xpt_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic [CW-1:0]  cmd_word,
  input logic [XCW-1:0] rb_xcode,
  input logic           rb_bit,
  input logic [NSW-1:0] sw_en,
  input logic [NSW-1:0] staged
);
  logic xres, rbres;
  assign xres  = (cmd_word[XC_HI:XC_LO] == 4'd6) || (cmd_word[XC_HI:XC_LO] == 4'd7) ||
                 (cmd_word[XC_HI:XC_LO] >= 4'd14);
  assign rbres = (rb_xcode == 4'd6) || (rb_xcode == 4'd7) || (rb_xcode >= 4'd14);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sw_en == '0 && rb_bit == 1'b0 && staged == '0));

  p_stage_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_word[LOAD_B]) |=> $stable(sw_en));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(sw_en));

  p_reserved_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_word[LOAD_B] && xres) |=> (sw_en == $past(staged)));

  p_reserved_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && xres) |=> $stable(staged));

  p_rb_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rbres |=> !rb_bit);
endmodule

bind xpt_switch_bank xpt_switch_bank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_word  (cmd_word),
  .rb_xcode  (rb_xcode),
  .rb_bit    (rb_bit),
  .sw_en     (sw_en),
  .staged    (staged_q)
);

// File: tb/tb_xpt_switch_bank.sv
module tb_xpt_switch_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [3:0]  rb_xcode = '0;
  logic [2:0]  rb_ycode = '0;
  logic        rb_bit;
  logic [95:0] sw_en;

  logic [95:0] exp_act = '0;
  logic [95:0] exp_st  = '0;
  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  xpt_switch_bank dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .rb_xcode(rb_xcode), .rb_ycode(rb_ycode), .rb_bit(rb_bit), .sw_en(sw_en)
  );

  // Independent X-code table from the requirements; -1 means reserved.
  function automatic int xline(input logic [3:0] c);
    case (c)
      4'd0: return 0;  4'd1: return 1;  4'd2: return 2;  4'd3: return 3;
      4'd4: return 4;  4'd5: return 5;  4'd8: return 6;  4'd9: return 7;
      4'd10: return 8; 4'd11: return 9; 4'd12: return 10; 4'd13: return 11;
      default: return -1;
    endcase
  endfunction

  task automatic chk_vec(input string tag, input logic [95:0] got, input logic [95:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: sw_en got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic got, input logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: rb_bit got %b expected %b", tag, got, exp);
    end
  endtask

  // Drive one command for one edge, update the model, sample after the edge.
  task automatic send(input logic d, input logic [3:0] xc, input logic [2:0] yc,
                      input logic ld, input logic [6:0] junk = 7'd0, input logic v = 1'b1);
    int xi;
    @(negedge clk);
    cmd_valid = v;
    cmd_word  = {d, xc, yc, junk, ld};
    @(posedge clk);
    if (v && rst_n) begin
      xi = xline(xc);
      if (xi >= 0) exp_st[xi*8 + int'(yc)] = d;
      if (ld) exp_act = exp_st;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
  endtask

  task automatic read_sw(input string tag, input logic [3:0] xc, input logic [2:0] yc);
    int  xi;
    logic e;
    @(negedge clk);
    rb_xcode = xc;
    rb_ycode = yc;
    @(posedge clk);
    xi = xline(xc);
    e  = (xi >= 0) ? exp_act[xi*8 + int'(yc)] : 1'b0;
    @(negedge clk);
    chk_bit(tag, rb_bit, e);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    exp_act = '0; exp_st = '0;
    chk_vec("R1 reset state", sw_en, '0);
    chk_bit("R1 reset readback", rb_bit, 1'b0);
  endtask

  task automatic t_stage_only;
    send(1'b1, 4'd0, 3'd0, 1'b0);
    chk_vec("R2 staged write not active", sw_en, exp_act);
    read_sw("R2 readback of staged-only switch", 4'd0, 3'd0);
  endtask

  task automatic t_load_group;
    send(1'b1, 4'd8, 3'd3, 1'b1);
    chk_vec("R3 load copies staged plus own word", sw_en, exp_act);
    send(1'b1, 4'd1, 3'd1, 1'b0);
    send(1'b1, 4'd5, 3'd7, 1'b0);
    chk_vec("R4 queued words still hidden", sw_en, exp_act);
    send(1'b1, 4'd13, 3'd7, 1'b1);
    chk_vec("R4 queued words applied together", sw_en, exp_act);
    chk_vec("R6 X11Y7 is top bit", {sw_en[95], 95'd0}, {1'b1, 95'd0});
  endtask

  task automatic t_xsweep;
    for (int c = 0; c < 16; c++) send(1'b1, 4'(c), 3'(c % 8), 1'b1);
    chk_vec("R5 X code sweep mapping", sw_en, exp_act);
  endtask

  task automatic t_open;
    send(1'b0, 4'd8, 3'd3, 1'b1);
    chk_vec("R7 data 0 opens switch", sw_en, exp_act);
  endtask

  task automatic t_reserved;
    send(1'b1, 4'd2, 3'd2, 1'b0);
    send(1'b1, 4'd6, 3'd2, 1'b1);
    chk_vec("R8 reserved code with load still copies", sw_en, exp_act);
    send(1'b0, 4'd15, 3'd0, 1'b1);
    chk_vec("R8 reserved code 15 writes nothing", sw_en, exp_act);
  endtask

  task automatic t_ignored;
    send(1'b1, 4'd3, 3'd4, 1'b1, 7'h7F);
    chk_vec("R11 don't-care bits ignored", sw_en, exp_act);
    send(1'b1, 4'd4, 3'd6, 1'b1, 7'd0, 1'b0);
    chk_vec("R11 invalid word ignored", sw_en, exp_act);
  endtask

  task automatic t_cross;
    for (int y = 0; y < 8; y++) send(1'b1, 4'd3, 3'(y), 1'b0);
    for (int c = 0; c < 14; c++) send(1'b1, 4'(c), 3'd5, 1'b0);
    send(1'b0, 4'd7, 3'd0, 1'b1);
    chk_vec("R12 one X to many Y and many X to one Y", sw_en, exp_act);
  endtask

  task automatic t_readback;
    read_sw("R10 readback X3Y6 closed", 4'd3, 3'd6);
    read_sw("R10 readback X11Y5 closed", 4'd13, 3'd5);
    read_sw("R10 readback X6Y3 open", 4'd8, 3'd3);
    read_sw("R10 readback reserved code 7", 4'd7, 3'd5);
    read_sw("R10 readback reserved code 14", 4'd14, 3'd5);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    rst_n = 1'b0;
    exp_act = '0; exp_st = '0;
    send(1'b1, 4'd9, 3'd1, 1'b0);
    send(1'b1, 4'd0, 3'd2, 1'b1);
    chk_vec("R9 commands in reset ignored", sw_en, '0);
    @(negedge clk);
    rst_n = 1'b1;
    send(1'b0, 4'd6, 3'd0, 1'b1);
    chk_vec("R9 nothing staged during reset", sw_en, '0);
    chk_vec("R1 reset cleared all", sw_en, exp_act);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_stage_only();
    t_load_group();
    t_xsweep();
    t_open();
    t_reserved();
    t_ignored();
    t_cross();
    t_readback();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule